// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs the timing of a successive-approximation converter. It divides the core clock into a conversion-period tick. It opens an acquisition window when software asks for a sample. It closes that window on a selectable trigger, and then counts out a fixed-length conversion. During the conversion it collects the converter's answer one bit per period and writes the finished word to a result register, pulsing a done flag as it does so.

The trigger that ends acquisition can be one of three things. It can be software dropping its sample request. It can be an edge on one of three external event lines. It can be a timer inside the block, which also restarts acquisition after every conversion. Dropping the global enable stops the sequence at once. No partial result is written, and a two-period guard interval must pass before a new acquisition can begin. The analog front end and the channel multiplexer sit outside this block.

The core clock `clk` runs at twice the instruction rate. A divide setting `D` therefore gives one conversion period of P = D + 1 clock cycles. In the text below, a "tick" is the last clock cycle of each period.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The conversion-period tick repeats every `adcs`+1 clock cycles. All acquisition, conversion and guard transitions happen on tick edges, so a whole auto-mode sample-and-convert cycle lasts exactly (sample time + 12) × P clocks.
- R2: With `trig_src` = 3'b111, conversion starts after the acquisition window has lasted max(`samc`,1) periods. A programmed `samc` of zero behaves as one.
- R3: A conversion lasts 12 periods. In each of its first RES_W periods, `res_bit` is captured, most significant bit first. The finished word appears on `result` at the edge where `conv_o` falls, and `result` changes at no other time.
- R4: `done` is high for exactly one cycle, at the edge where `result` is updated. `samp_o` and `conv_o` are never high together.
- R5: With `trig_src` = 3'b000, acquisition runs while `samp_bit` is high. Conversion begins on the first tick that sees `samp_bit` low. When the conversion ends, the block goes idle until `samp_bit` is raised again.
- R6: Codes 3'b001, 3'b010 and 3'b011 end acquisition on a rising edge of `ext_trig[0]`, `ext_trig[1]` and `ext_trig[2]` respectively. Each line passes through a synchronizer and edge detector that advance only on ticks, so conversion starts 2P+1 to 3P clocks after the line rises. Edges on unselected lines are ignored. Codes 3'b100 to 3'b110 never end acquisition.
- R7: In auto mode, a new acquisition window opens at the same edge at which a conversion completes, for as long as `adc_on` stays high, without `samp_bit` being raised again.
- R8: `adc_on` low during acquisition or conversion clears `samp_o` and `conv_o` at the next edge. `result` keeps its previous value and `done` stays low.
- R9: An abort wins over an auto-start or a conversion completion that falls on the same edge: no conversion starts and no result is written.
- R10: After an abort, a pending sample request starts acquisition on the third tick after the abort edge. This gives 2P+1 to 3P clocks between re-enabling and `samp_o` rising.
- R11: Under reset, `samp_o`, `conv_o`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the instruction rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_on | input | 1 | Global enable; clearing it aborts |
| samp_bit | input | 1 | Software sample request |
| trig_src | input | 3 | Trigger source select |
| samc | input | SAMC_W | Auto-mode acquisition length in periods |
| adcs | input | DIV_W | Conversion-period divide setting |
| ext_trig | input | N_EXT | External event lines (interrupt, timer, PWM) |
| res_bit | input | 1 | Serial bit from the converter stub |
| samp_o | output | 1 | Acquisition active |
| conv_o | output | 1 | Conversion active |
| done | output | 1 | One-cycle result-written pulse |
| result | output | RES_W | Last completed conversion word |

## Verification
The bench sweeps divide settings and sample times, including zero, so that a design which ran acquisition for zero periods, or miscounted the period length, would show a wrong interval between `samp_o` and `conv_o`. It drops the enable on the exact edge of an auto-start and on the exact edge of conversion completion. A design that let either event win would raise `conv_o` or overwrite `result`. It measures the guard delay, so a design that skipped the guard, or started acquisition one tick early, would raise `samp_o` too soon. On each external source it also pulses the wrong line first, which exposes a swapped line mapping.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ACQ   = 2'd1,
      SQ_CONV  = 2'd2,
      SQ_GUARD = 2'd3
   } sq_state_e;

   localparam logic [2:0] TRG_SOFT = 3'b000;
   localparam logic [2:0] TRG_IRQ  = 3'b001;
   localparam logic [2:0] TRG_TMR  = 3'b010;
   localparam logic [2:0] TRG_PWM  = 3'b011;
   localparam logic [2:0] TRG_AUTO = 3'b111;

   localparam int LINE_IRQ = 0;
   localparam int LINE_TMR = 1;
   localparam int LINE_PWM = 2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_tad_div.sv
module adc_tad_div #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] adcs,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= adcs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int N_EXT  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [N_EXT-1:0] lines,
   output logic [N_EXT-1:0] rise_o
);
   for (genvar i = 0; i < N_EXT; i++) begin : g_line
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sh <= '0;
         else if (tick)
            sh <= {sh[STAGES-1:0], lines[i]};
      end
      assign rise_o[i] = sh[STAGES-1] & ~sh[STAGES];
   end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int SAMC_W  = 5,
   parameter int CONV_T  = 12,
   parameter int RES_W   = 10,
   parameter int GUARD_T = 2,
   parameter int N_EXT   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              adc_on,
   input  logic              samp_bit,
   input  logic [2:0]        trig_src,
   input  logic [SAMC_W-1:0] samc,
   input  logic [N_EXT-1:0]  ext_rise,
   output logic              acq_o,
   output logic              conv_o,
   output logic              cap_o,
   output logic              commit_o
);
   localparam int CNT_W = imax(SAMC_W, $clog2(imax(CONV_T, GUARD_T) + 1));
   localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_T - 1);
   localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_T - 1);

   sq_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [SAMC_W-1:0] samc_eff;
   logic              acq_full;
   logic              hit;
   logic              abort;

   assign samc_eff = (samc == '0) ? SAMC_W'(1) : samc;
   assign acq_full = (int'(cnt) + 1) >= int'(samc_eff);
   assign abort    = !adc_on && ((st == SQ_ACQ) || (st == SQ_CONV));

   always_comb begin
      case (trig_src)
         TRG_SOFT: hit = !samp_bit;
         TRG_IRQ:  hit = ext_rise[LINE_IRQ];
         TRG_TMR:  hit = ext_rise[LINE_TMR];
         TRG_PWM:  hit = ext_rise[LINE_PWM];
         TRG_AUTO: hit = acq_full;
         default:  hit = 1'b0;
      endcase
   end

   assign acq_o    = (st == SQ_ACQ);
   assign conv_o   = (st == SQ_CONV);
   assign cap_o    = tick && adc_on && (st == SQ_CONV) && (int'(cnt) < RES_W);
   assign commit_o = tick && adc_on && (st == SQ_CONV) && (cnt == CONV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         cnt <= '0;
      end else if (abort) begin
         st  <= SQ_GUARD;
         cnt <= '0;
      end else if (tick) begin
         case (st)
            SQ_IDLE: begin
               if (adc_on && samp_bit) begin
                  st  <= SQ_ACQ;
                  cnt <= '0;
               end
            end
            SQ_ACQ: begin
               if (hit) begin
                  st  <= SQ_CONV;
                  cnt <= '0;
               end else if (cnt != '1) begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_CONV: begin
               if (cnt == CONV_LAST) begin
                  st  <= (trig_src == TRG_AUTO) ? SQ_ACQ : SQ_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == GUARD_LAST) begin
                  st  <= SQ_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/adc_sar_capture.sv
module adc_sar_capture #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic             commit,
   input  logic             res_bit,
   output logic [RES_W-1:0] result,
   output logic             done
);
   logic [RES_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= commit;
         if (cap)
            sh <= {sh[RES_W-2:0], res_bit};
         if (commit)
            result <= sh;
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DIV_W   = 6,
   parameter int SAMC_W  = 5,
   parameter int RES_W   = 10,
   parameter int CONV_T  = 12,
   parameter int GUARD_T = 2,
   parameter int N_EXT   = 3,
   parameter int STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adc_on,
   input  logic              samp_bit,
   input  logic [2:0]        trig_src,
   input  logic [SAMC_W-1:0] samc,
   input  logic [DIV_W-1:0]  adcs,
   input  logic [N_EXT-1:0]  ext_trig,
   input  logic              res_bit,
   output logic              samp_o,
   output logic              conv_o,
   output logic              done,
   output logic [RES_W-1:0]  result
);
   if (RES_W < 2 || RES_W >= CONV_T) begin : g_bad_res
      $error("RES_W must be at least 2 and below CONV_T");
   end
   if (N_EXT <= LINE_PWM) begin : g_bad_ext
      $error("N_EXT must cover every external trigger line");
   end
   if (STAGES < 2 || GUARD_T < 1) begin : g_bad_misc
      $error("STAGES must be at least 2 and GUARD_T at least 1");
   end

   logic             tick;
   logic [N_EXT-1:0] ext_rise;
   logic             cap;
   logic             commit;

   adc_tad_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .adcs  (adcs),
      .tick  (tick)
   );

   adc_trig_sync #(.N_EXT(N_EXT), .STAGES(STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .lines  (ext_trig),
      .rise_o (ext_rise)
   );

   adc_seq_fsm #(
      .SAMC_W  (SAMC_W),
      .CONV_T  (CONV_T),
      .RES_W   (RES_W),
      .GUARD_T (GUARD_T),
      .N_EXT   (N_EXT)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .adc_on   (adc_on),
      .samp_bit (samp_bit),
      .trig_src (trig_src),
      .samc     (samc),
      .ext_rise (ext_rise),
      .acq_o    (samp_o),
      .conv_o   (conv_o),
      .cap_o    (cap),
      .commit_o (commit)
   );

   adc_sar_capture #(.RES_W(RES_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap),
      .commit  (commit),
      .res_bit (res_bit),
      .result  (result),
      .done    (done)
   );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adc_on,
   input logic             samp_o,
   input logic             conv_o,
   input logic             done,
   input logic [RES_W-1:0] result
);
   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(samp_o && conv_o)); // R4
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result)); // R3
   AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(conv_o)); // R3
   AST_CONV_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(conv_o) |-> $past(samp_o)); // R2
   AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!adc_on && (samp_o || conv_o)) |=> (!samp_o && !conv_o && !done)); // R8
   AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) $rose(samp_o) |-> $past(adc_on)); // R9
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .adc_on (adc_on),
   .samp_o (samp_o),
   .conv_o (conv_o),
   .done   (done),
   .result (result)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
   localparam int RW = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          adc_on = 1'b1;
   logic          samp_bit = 1'b0;
   logic          res_bit = 1'b0;
   logic [2:0]    trig_src = 3'b000;
   logic [2:0]    ext_trig = 3'b000;
   logic [4:0]    samc = 5'd0;
   logic [5:0]    adcs = 6'd0;
   logic          samp_o, conv_o, done;
   logic [RW-1:0] result;

   int n_vec = 0;
   int n_bad = 0;
   int P = 1;
   int sconv = 0;
   int cyc = 0;
   logic prev_conv = 1'b0;
   logic [RW-1:0] pat = '0;

   adc_seq_ctrl #(.RES_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .adc_on(adc_on), .samp_bit(samp_bit),
      .trig_src(trig_src), .samc(samc), .adcs(adcs), .ext_trig(ext_trig),
      .res_bit(res_bit), .samp_o(samp_o), .conv_o(conv_o), .done(done),
      .result(result)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic chk(input string rq, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic chk_rng(input string rq, input int act, input int lo, input int hi);
      n_vec++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d..%0d", rq, act, lo, hi);
      end
   endtask

   // One clock; then drive the converter stub bit for the current period.
   task automatic step();
      int idx;
      @(posedge clk);
      #1;
      if (conv_o && !prev_conv) sconv = 0;
      else if (conv_o) sconv++;
      prev_conv = conv_o;
      idx = sconv / P;
      res_bit = (conv_o && idx < RW) ? pat[RW-1-idx] : 1'b0;
   endtask

   // what: 0 samp_o high, 1 conv_o high, 2 done high
   task automatic wait_for(input int what, input int lim, output int n);
      n = 0;
      while (1) begin
         step();
         n++;
         if ((what == 0 && samp_o) || (what == 1 && conv_o) || (what == 2 && done)) return;
         if (n >= lim) begin
            n = -1;
            return;
         end
      end
   endtask

   task automatic do_reset(input int a);
      rst_n = 1'b0;
      adc_on = 1'b1;
      samp_bit = 1'b0;
      ext_trig = 3'b000;
      adcs = 6'(a);
      P = a + 1;
      repeat (3) step();
      rst_n = 1'b1;
   endtask

   initial begin
      int n;
      int se;
      int old;
      int alist[4];
      int slist[5];
      alist = '{0, 1, 3, 5};
      slist = '{0, 1, 2, 5, 31};

      // R11 reset state
      do_reset(0);
      chk("R11 samp_o", int'(samp_o), 0);
      chk("R11 conv_o", int'(conv_o), 0);
      chk("R11 done", int'(done), 0);
      chk("R11 result", int'(result), 0);
      step();
      chk("R11 idle without request", int'(samp_o), 0);

      // Auto mode sweep: R1 R2 R3 R4 R7
      foreach (alist[i]) begin
         foreach (slist[j]) begin
            do_reset(alist[i]);
            trig_src = 3'b111;
            samc = 5'(slist[j]);
            se = (slist[j] == 0) ? 1 : slist[j];
            pat = RW'(alist[i] * 97 + slist[j] * 13 + 21);
            samp_bit = 1'b1;
            wait_for(0, 4 * P, n);
            samp_bit = 1'b0;
            wait_for(1, 40 * P, n);
            chk("R2 acquisition length", n, se * P);
            wait_for(2, 20 * P, n);
            chk("R3 conversion length", n, 12 * P);
            chk("R3 result word", int'(result), int'(pat));
            chk("R7 restart at completion", int'(samp_o), 1);
            chk("R4 exclusive phases", int'(conv_o), 0);
            pat = ~pat;
            step();
            chk("R4 done one cycle", int'(done), 0);
            wait_for(2, (se + 14) * P, n);
            chk("R1 full cycle period", n + 1, (se + 12) * P);
            chk("R3 second result", int'(result), int'(pat));
         end
      end

      // Software trigger: R5
      do_reset(2);
      trig_src = 3'b000;
      samc = 5'd0;
      pat = 10'h26D;
      samp_bit = 1'b1;
      wait_for(0, 4 * P, n);
      repeat (10) step();
      chk("R5 acquisition held", int'(samp_o), 1);
      chk("R5 no conversion yet", int'(conv_o), 0);
      samp_bit = 1'b0;
      wait_for(1, 3 * P, n);
      chk_rng("R5 conversion on next tick", n, 1, P);
      wait_for(2, 14 * P, n);
      chk("R5 result", int'(result), int'(pat));
      chk("R5 idle after conversion", int'(samp_o), 0);
      repeat (5 * P) step();
      chk("R5 stays idle", int'(samp_o) + int'(conv_o), 0);

      // External triggers: R6
      for (int c = 1; c <= 3; c++) begin
         do_reset(1);
         trig_src = 3'(c);
         pat = RW'(c * 211 + 3);
         samp_bit = 1'b1;
         wait_for(0, 4 * P, n);
         samp_bit = 1'b0;
         ext_trig = 3'(1 << (c % 3));
         repeat (8 * P) step();
         chk("R6 unselected line ignored", int'(conv_o), 0);
         chk("R6 acquisition continues", int'(samp_o), 1);
         ext_trig = 3'b000;
         repeat (4 * P) step();
         ext_trig = 3'(1 << (c - 1));
         wait_for(1, 5 * P, n);
         chk_rng("R6 synchronizer latency", n, 2 * P + 1, 3 * P);
         ext_trig = 3'b000;
         wait_for(2, 14 * P, n);
         chk("R6 result", int'(result), int'(pat));
      end
      do_reset(1);
      trig_src = 3'b100;
      samp_bit = 1'b1;
      wait_for(0, 4 * P, n);
      ext_trig = 3'b111;
      repeat (40 * P) step();
      chk("R6 code without trigger", int'(samp_o) * 2 + int'(conv_o), 2);
      ext_trig = 3'b000;

      // Abort mid-conversion and guard: R8 R10
      do_reset(2);
      trig_src = 3'b111;
      samc = 5'd1;
      pat = 10'h2B5;
      samp_bit = 1'b1;
      wait_for(2, 30 * P, n);
      old = int'(result);
      pat = 10'h14A;
      wait_for(1, 4 * P, n);
      repeat (5 * P) step();
      adc_on = 1'b0;
      step();
      chk("R8 phases cleared", int'(samp_o) + int'(conv_o), 0);
      chk("R8 no done", int'(done), 0);
      chk("R8 result kept", int'(result), old);
      adc_on = 1'b1;
      wait_for(0, 5 * P, n);
      chk_rng("R10 guard delay", n, 2 * P + 1, 3 * P);
      chk("R8 result kept through guard", int'(result), old);
      wait_for(2, 20 * P, n);
      chk("R8 recovery result", int'(result), int'(pat));

      // Abort on the auto-start edge and on the completion edge: R9
      do_reset(1);
      trig_src = 3'b111;
      samc = 5'd3;
      pat = 10'h0F3;
      samp_bit = 1'b1;
      wait_for(2, 30 * P, n);
      old = int'(result);
      pat = 10'h30C;
      repeat (3 * P - 1) step();
      chk("R9 still acquiring before edge", int'(samp_o) * 2 + int'(conv_o), 2);
      adc_on = 1'b0;
      step();
      chk("R9 auto-start suppressed", int'(conv_o), 0);
      chk("R9 acquisition stopped", int'(samp_o), 0);
      adc_on = 1'b1;
      wait_for(0, 5 * P, n);
      chk_rng("R10 guard after start abort", n, 2 * P + 1, 3 * P);
      wait_for(1, 5 * P, n);
      repeat (12 * P - 1) step();
      chk("R9 converting before final edge", int'(conv_o), 1);
      adc_on = 1'b0;
      step();
      chk("R9 completion suppressed", int'(done), 0);
      chk("R9 result kept", int'(result), old);
      chk("R9 conversion stopped", int'(conv_o), 0);
      adc_on = 1'b1;
      repeat (4) step();

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule